// File: doc/BRIEF.md
# Flash Factory Program and Verify Sequencer

This block is the device-side engine behind a bulk factory-programming mode of a word-wide flash memory. Once software has entered the mode (shown here by a one-cycle `enter` pulse), the host streams bus writes into it. Each write carries an address and a 16-bit word. In the program phase each word is burned into a small internal cell array. Burning can only clear bits, so a cell becomes its old value AND the written word. A cell busy period of `PROG_CYC` cycles stands in for real cell timing.

Writing all ones to an address outside the start block closes the program phase and opens the verify phase. In the verify phase the host resends the same stream. Each word is compared with the stored cell. A mismatched cell is reprogrammed once and then checked again, and if it still differs a sticky error flag is raised. A second all-ones write outside the start block returns the sequencer to read mode and sets the done flag.

Writes arrive on a valid/ready stream. A transfer takes place on a rising clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` drops for the whole time a word is being processed, and it is low in read mode. The host may hold `wr_valid` high across any number of cycles: the word simply waits. A word offered while `wr_ready` is low is never taken. The status byte and the array read port are plain signals.

Top module: `fpv_seq`

## Requirements
- R1: After synchronous reset, `status` is 8'h80 (bit 7 done = 1; bit 4 error, bit 0 busy and all other bits 0). `wr_ready` is 0 and every array cell reads 16'hFFFF.
- R2: An `enter` pulse in read mode clears the done and error bits, and `wr_ready` is 1 from the next cycle.
- R3: A word transfers only on an edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` and busy (bit 0) are never high together. A word offered while `wr_ready` is 0 changes no cell and no status bit.
- R4: The first word of a phase latches its address as the start address, and its block is the address bits above the low `BLK_W` bits. In the program phase a cell at target address t becomes old(t) AND word.
- R5: A later word whose address equals the start address targets the previous target plus one. The low `BLK_W` offset bits wrap inside the block. A later word with any other in-block address targets that address.
- R6: After a program-phase word is taken, busy is 1 for exactly `PROG_CYC` cycles, beginning in the cycle after the transfer.
- R7: A later word outside the start block with data 16'hFFFF ends the program phase without programming. The verify phase then begins and `wr_ready` stays 1. A later out-of-block word with any other data is discarded and the phase continues.
- R8: In the verify phase the same addressing applies. A word that equals its target cell keeps busy high for exactly 1 cycle and changes nothing.
- R9: A verify word that differs from its cell reprograms the cell (AND) and keeps busy high for `PROG_CYC`+2 cycles. If the cell still differs afterwards, because the word needs a 0-to-1 change, error bit 4 is set. The error bit stays set until the next `enter`.
- R10: A later verify word outside the start block with data 16'hFFFF returns to read mode. Done bit 7 is 1 and `wr_ready` is 0 from the next cycle.
- R11: `enter` has no effect outside read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enter | input | 1 | One-cycle request to start a factory session (read mode only) |
| wr_valid | input | 1 | Host offers a word |
| wr_ready | output | 1 | Sequencer can take a word this cycle |
| wr_addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Word value |
| status | output | 8 | Bit 7 done/read mode, bit 4 error, bit 0 busy |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read word (combinational) |

## Verification
The assertions assume that `enter` is pulsed only in read mode. They also assume the host never holds `wr_valid` across the edge that ends a phase. Under those conditions a rise of done can be traced to an accepted all-ones word, and a fall of the error bit can be traced to an `enter`. The bench meets both conditions. It drives each word for exactly one accepted edge and waits for `wr_ready` before offering the next. It pulses `enter` inside a phase only to show that `enter` is ignored there. The one deliberate word offered while busy is withdrawn before `wr_ready` returns.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_PFIRST,
    ST_PNEXT,
    ST_PPROG,
    ST_VFIRST,
    ST_VNEXT,
    ST_VCMP,
    ST_VPROG,
    ST_VRECHK
  } fpv_state_e;

  localparam int SR_BUSY = 0;
  localparam int SR_ERR  = 4;
  localparam int SR_DONE = 7;

endpackage

// File: rtl/fpv_timer.sv
module fpv_timer #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CW'(CYC - 1);
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fpv_addr.sv
module fpv_addr #(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 6
) (
  input  logic              first,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_blk,
  output logic [ADDR_W-1:0] tgt
);
  localparam int HI_W = ADDR_W - BLK_W;

  logic [HI_W-1:0]  blk_start, blk_addr;
  logic [BLK_W-1:0] next_off;

  assign blk_start = start[ADDR_W-1:BLK_W];
  assign blk_addr  = addr[ADDR_W-1:BLK_W];
  assign next_off  = cur[BLK_W-1:0] + 1'b1;

  always_comb begin
    in_blk = first || (blk_addr == blk_start);
    if (first)
      tgt = addr;
    else if (addr == start)
      tgt = {blk_start, next_off};
    else
      tgt = addr;
  end
endmodule

// File: rtl/fpv_array.sv
module fpv_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic [DATA_W-1:0] cmp_word,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // cells start erased; programming only clears bits
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (we) begin
      cells[waddr] <= cells[waddr] & wdata;
    end
  end

  assign cmp_word = cells[cmp_addr];
  assign rd_word  = cells[rd_addr];
endmodule

// File: rtl/fpv_seq.sv
module fpv_seq #(
  parameter int ADDR_W   = 8,
  parameter int BLK_W    = 6,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        status,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import fpv_pkg::*;

  fpv_state_e        st_q;
  logic [ADDR_W-1:0] start_q, cur_q, tgt_q;
  logic [DATA_W-1:0] dat_q;
  logic              err_q, done_q;

  logic              first, accepting, busy, vphase;
  logic              acc, take, drop, term;
  logic              in_blk;
  logic [ADDR_W-1:0] tgt;
  logic [DATA_W-1:0] cmp_word;
  logic              match, tmr_zero, tmr_load, tmr_run, we;

  assign first     = (st_q == ST_PFIRST) || (st_q == ST_VFIRST);
  assign vphase    = (st_q == ST_VFIRST) || (st_q == ST_VNEXT);
  assign accepting = first || (st_q == ST_PNEXT) || (st_q == ST_VNEXT);
  assign busy      = (st_q == ST_PPROG) || (st_q == ST_VCMP) ||
                     (st_q == ST_VPROG) || (st_q == ST_VRECHK);

  assign acc  = wr_valid && accepting;
  assign take = acc && in_blk;
  assign drop = acc && !in_blk;
  assign term = drop && (&wr_data);

  assign match    = (cmp_word == dat_q);
  assign tmr_load = take || ((st_q == ST_VCMP) && !match);
  assign tmr_run  = (st_q == ST_PPROG) || (st_q == ST_VPROG);
  assign we       = tmr_run && tmr_zero;

  fpv_addr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_addr (
    .first (first),
    .start (start_q),
    .cur   (cur_q),
    .addr  (wr_addr),
    .in_blk(in_blk),
    .tgt   (tgt)
  );

  fpv_timer #(.CYC(PROG_CYC)) u_timer (
    .clk (clk),
    .rst (rst),
    .load(tmr_load),
    .run (tmr_run),
    .zero(tmr_zero)
  );

  fpv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .waddr   (tgt_q),
    .wdata   (dat_q),
    .cmp_addr(tgt_q),
    .cmp_word(cmp_word),
    .rd_addr (rd_addr),
    .rd_word (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_READ;
      start_q <= '0;
      cur_q   <= '0;
      tgt_q   <= '0;
      dat_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b1;
    end else begin
      if (take) begin
        if (first) start_q <= wr_addr;
        cur_q <= tgt;
        tgt_q <= tgt;
        dat_q <= wr_data;
      end
      unique case (st_q)
        ST_READ: begin
          if (enter) begin
            st_q   <= ST_PFIRST;
            done_q <= 1'b0;
            err_q  <= 1'b0;
          end
        end
        ST_PFIRST, ST_PNEXT: begin
          if (take)      st_q <= ST_PPROG;
          else if (term) st_q <= ST_VFIRST;
        end
        ST_PPROG: begin
          if (tmr_zero) st_q <= ST_PNEXT;
        end
        ST_VFIRST, ST_VNEXT: begin
          if (take) begin
            st_q <= ST_VCMP;
          end else if (term && vphase) begin
            st_q   <= ST_READ;
            done_q <= 1'b1;
          end
        end
        ST_VCMP: begin
          st_q <= match ? ST_VNEXT : ST_VPROG;
        end
        ST_VPROG: begin
          if (tmr_zero) st_q <= ST_VRECHK;
        end
        ST_VRECHK: begin
          if (!match) err_q <= 1'b1;
          st_q <= ST_VNEXT;
        end
        default: st_q <= ST_READ;
      endcase
    end
  end

  assign wr_ready = accepting;

  always_comb begin
    status          = '0;
    status[SR_BUSY] = busy;
    status[SR_ERR]  = err_q;
    status[SR_DONE] = done_q;
  end
endmodule

// File: rtl/fpv_seq_chk.sv
module fpv_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enter,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [7:0]        status
);
  import fpv_pkg::*;

  // R3
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_ready && status[SR_BUSY]));

  // R6
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[SR_BUSY]) |-> $past(wr_valid && wr_ready));

  // R10
  done_after_term_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[SR_DONE]) |-> $past(wr_valid && wr_ready && (&wr_data)));

  // R10
  done_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    status[SR_DONE] |-> !wr_ready);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[SR_ERR]) |-> $past(enter));

  // R1
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status & 8'h6E) == 8'h00);
endmodule

bind fpv_seq fpv_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fpv_seq_chk (
  .clk     (clk),
  .rst     (rst),
  .enter   (enter),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_data (wr_data),
  .status  (status)
);

// File: tb/test_fpv_seq.sv
module test_fpv_seq;
  localparam int AW = 8;
  localparam int BW = 6;
  localparam int DW = 16;
  localparam int PC = 3;

  logic          clk = 1'b0;
  logic          rst, enter, wr_valid, wr_ready;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [7:0]    status;

  always #10 clk = ~clk;

  fpv_seq #(.ADDR_W(AW), .BLK_W(BW), .DATA_W(DW), .PROG_CYC(PC)) i_fpv_seq (
    .clk(clk), .rst(rst), .enter(enter), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [256];
  logic [AW-1:0] s_a [128];
  logic [DW-1:0] s_d [128];
  int            n_s;
  logic [AW-1:0] start_b, cur_b;
  logic          err_b;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a);
    rd_addr = a;
    #1;
    chk(tag, int'(rd_data), int'(mdl[a]));
  endtask

  // offer one word, optionally poke a word while busy, return busy length
  task automatic send(logic [AW-1:0] a, logic [DW-1:0] d, logic poke, output int nb);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    nb = 0;
    if (poke) begin
      wr_valid = 1'b1; wr_addr = 8'h46; wr_data = 16'h0000;
      @(negedge clk);
      wr_valid = 1'b0;
      nb = 1;
    end
    while (status[0]) begin nb++; @(negedge clk); end
  endtask

  function automatic logic [AW-1:0] target(logic first, logic [AW-1:0] a);
    if (first) return a;
    if (a == start_b) return {start_b[AW-1:BW], BW'(cur_b[BW-1:0] + 1'b1)};
    return a;
  endfunction

  task automatic pword(logic first, logic [AW-1:0] a, logic [DW-1:0] d, logic poke);
    logic [AW-1:0] t;
    int nb;
    t = target(first, a);
    if (first) start_b = a;
    cur_b = t;
    mdl[t] = mdl[t] & d;
    s_a[n_s] = a; s_d[n_s] = d; n_s++;
    send(a, d, poke, nb);
    chk("R6 program busy length", nb, PC);
    rd_chk("R4 R5 programmed cell", t);
  endtask

  task automatic vword(logic first, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [AW-1:0] t;
    int nb, eb;
    t = target(first, a);
    if (first) start_b = a;
    cur_b = t;
    if (mdl[t] == d) eb = 1;
    else begin
      eb = PC + 2;
      mdl[t] = mdl[t] & d;
      if (mdl[t] != d) err_b = 1'b1;
    end
    send(a, d, 1'b0, nb);
    chk((eb == 1) ? "R8 match busy" : "R9 mismatch busy", nb, eb);
    chk("R9 error bit", int'(status[4]), int'(err_b));
    rd_chk("R9 verified cell", t);
  endtask

  task automatic pulse_enter();
    @(negedge clk); enter = 1'b1;
    @(negedge clk); enter = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    logic [DW-1:0] vd;
    logic [AW-1:0] t;
    rst = 1'b1; enter = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
    n_s = 0; err_b = 1'b0; start_b = '0; cur_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(status), 'h80);
    chk("R1 ready", int'(wr_ready), 0);
    for (int i = 0; i < 256; i++) rd_chk("R1 erased cell", AW'(i));

    // R3 word offered in read mode is ignored
    wr_valid = 1'b1; wr_addr = 8'h05; wr_data = 16'h0000;
    repeat (2) @(negedge clk);
    wr_valid = 1'b0;
    rd_chk("R3 ignored in read mode", 8'h05);
    chk("R3 status unchanged", int'(status), 'h80);

    // R2 enter
    pulse_enter();
    chk("R2 status after enter", int'(status), 'h00);
    chk("R2 ready after enter", int'(wr_ready), 1);

    // program phase: start 0x48, auto-increment with wrap
    pword(1'b1, 8'h48, 16'hA5F0, 1'b0);
    for (int i = 1; i < 60; i++)
      pword(1'b0, 8'h48, DW'(16'hA5F0 ^ (i * 16'h1357)), 1'b0);
    // R5 jump, then resume increment after the jump; R3 poke while busy
    pword(1'b0, 8'h44, 16'h0F0F, 1'b1);
    pword(1'b0, 8'h48, 16'hF00F, 1'b0);
    rd_chk("R3 word offered while busy ignored", 8'h46);
    // R7 out-of-block non-ones is discarded
    send(8'h10, 16'h1234, 1'b0, nb);
    chk("R7 discard busy", nb, 0);
    rd_chk("R7 discarded cell", 8'h10);
    chk("R7 ready after discard", int'(wr_ready), 1);
    // R7 phase end
    send(8'h00, 16'hFFFF, 1'b0, nb);
    chk("R7 end busy", nb, 0);
    chk("R7 ready into verify", int'(wr_ready), 1);
    chk("R7 status into verify", int'(status), 'h00);
    for (int i = 0; i < 256; i++) rd_chk("R4 R5 array after program", AW'(i));

    // verify phase replay with two altered words
    for (int i = 0; i < n_s; i++) begin
      vd = s_d[i];
      if (i == 10 || i == 50) begin
        t = (i == 0) ? s_a[i] : target(1'b0, s_a[i]);
        if (i == 10) vd = mdl[t] & ~(mdl[t] & (~mdl[t] + 1'b1));
        else         vd = mdl[t] | (~mdl[t] & (mdl[t] + 1'b1));
      end
      vword(i == 0, s_a[i], vd);
      if (i == 50) begin
        // R11 enter ignored mid-phase
        pulse_enter();
        chk("R11 error kept", int'(status[4]), 1);
        chk("R11 ready kept", int'(wr_ready), 1);
      end
    end
    send(8'hF0, 16'hFFFF, 1'b0, nb);
    chk("R10 status after end", int'(status), 'h90);
    chk("R10 ready after end", int'(wr_ready), 0);
    pulse_enter();
    chk("R9 R2 error cleared by enter", int'(status), 'h00);

    // session 2: block 3 with jumps and offset wrap
    n_s = 0; err_b = 1'b0;
    pword(1'b1, 8'hC4, 16'h1111, 1'b0);
    pword(1'b0, 8'hD0, 16'h2222, 1'b0);
    pword(1'b0, 8'hC4, 16'h3333, 1'b0);
    pword(1'b0, 8'hFF, 16'h4444, 1'b0);
    pword(1'b0, 8'hC4, 16'h5555, 1'b0);
    rd_chk("R5 offset wrap to block base", 8'hC0);
    send(8'h00, 16'hFFFF, 1'b0, nb);
    for (int i = 0; i < n_s; i++) vword(i == 0, s_a[i], s_d[i]);
    send(8'h3F, 16'hFFFF, 1'b0, nb);
    chk("R10 clean session status", int'(status), 'h80);
    chk("R10 clean session ready", int'(wr_ready), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule